// File: doc/BRIEF.md
# Accelerator Session Handshake Controller

This block sits between a host processor and a reconfigurable compute unit that share a small local data memory. It runs each exchange as a fixed session. The host fills the shared memory with operands and picks the function the unit should run. A timed configuration phase follows, then the host issues a start. While the unit computes, the host is free to do its own work. Completion is reported through a held acknowledge. A two-sided barrier then closes the run and returns the memory to the host so the results can be read back.

The host drives the session through a small register port. One command register moves the session between its stages, and one register holds the function select. A status register reports the configuration and error flags, and a fourth register reports the stage. Memory ownership follows the stage. While the unit is running, a host memory access is held off rather than refused, and it completes on its own once the host owns the memory again. Sessions can be repeated, each with a new function select.

Top module: `accel_session_ctrl`

## Requirements
- R1: After reset the stage reads IDLE (code 0 at register address 3). The status register (address 2) reads 0, `cu_start` is low and `host_irq` is low.
- R2: Commands are written to address 0 with the code in bits [2:0]: 1 load, 2 configure, 3 start, 4 host-done, 5 collect, 6 end. Only these moves change the stage: IDLE→LOAD (load), LOAD→CONFIG (configure), DONE→COLLECT (collect), COLLECT→LOAD (load) and COLLECT→IDLE (end). Any other command leaves the stage as it is. Stage codes are IDLE 0, LOAD 1, CONFIG 2, RUN 3, DONE 4, COLLECT 5.
- R3: The configure command copies the function register (address 1, bits [FUNC_W-1:0]) to `cu_func`. From the cycle after that command, the busy status bit (bit 1) is high for exactly CFG_LAT cycles. The ready bit (bit 0) then rises.
- R4: A start in CONFIG while ready is set moves the stage to RUN. It also raises `cu_start` for exactly the first RUN cycle and clears the ready bit.
- R5: A start given at any other time leaves the stage unchanged and raises no `cu_start`. It sets the sticky error bit (status bit 3), which is cleared only by writing status with bit 3 set.
- R6: A `cu_done` pulse during RUN sets the acknowledge (status bit 2, also on `host_irq`). The acknowledge stays high until the host writes status with bit 2 set. A completion in the same cycle as that clear leaves the acknowledge set.
- R7: RUN ends only after both the host-done command and `cu_done` have been seen, in either order. The stage becomes DONE one cycle after the later of the two.
- R8: Outside RUN, a host memory access completes in the cycle it is requested (`hmem_ack` high, write on that edge). During RUN, a host request gets no `hmem_ack` and writes nothing. It completes once the stage leaves RUN.
- R9: A compute unit memory access is granted only in RUN. Its writes are then visible to the host.
- R10: A repeated session through COLLECT→LOAD→CONFIG takes a newly written function select onto `cu_func`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | 8 | Host register write data |
| reg_rdata | output | 8 | Host register read data for `reg_addr` |
| hmem_req | input | 1 | Host memory request, held until acknowledged |
| hmem_we | input | 1 | Host memory write enable |
| hmem_addr | input | AW (4) | Host memory address |
| hmem_wdata | input | DW (16) | Host memory write data |
| hmem_rdata | output | DW (16) | Host memory read data |
| hmem_ack | output | 1 | Host access completes this cycle |
| host_irq | output | 1 | Held completion acknowledge to the host |
| cu_start | output | 1 | One-cycle start to the compute unit |
| cu_func | output | FUNC_W (4) | Function selected for the compute unit |
| cu_done | input | 1 | Completion pulse from the compute unit |
| cu_mem_req | input | 1 | Compute unit memory request |
| cu_mem_we | input | 1 | Compute unit memory write enable |
| cu_mem_addr | input | AW (4) | Compute unit memory address |
| cu_mem_wdata | input | DW (16) | Compute unit memory write data |
| cu_mem_rdata | output | DW (16) | Compute unit memory read data |
| cu_mem_gnt | output | 1 | Compute unit access granted |

## Verification
Two pairs of events can land on the same edge. The first pair is a completion pulse from the unit and a host write that clears the acknowledge. The bench drives both in one cycle and expects `host_irq` to stay high afterwards. The second pair is a host memory write stalled during RUN and the barrier closing. The bench holds the write across the barrier and judges it by three observations: `hmem_ack` stays low while the unit reads the old word, `hmem_ack` rises in the first DONE cycle, and the stalled data is read back during COLLECT.

// File: rtl/sess_pkg.sv
`timescale 1ns/1ps
package sess_pkg;

  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOAD    = 3'd1,
    ST_CONFIG  = 3'd2,
    ST_RUN     = 3'd3,
    ST_DONE    = 3'd4,
    ST_COLLECT = 3'd5
  } sess_state_e;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_LOAD    = 3'd1,
    CMD_CONFIG  = 3'd2,
    CMD_START   = 3'd3,
    CMD_HDONE   = 3'd4,
    CMD_COLLECT = 3'd5,
    CMD_END     = 3'd6
  } sess_cmd_e;

  localparam logic [1:0] RA_CMD   = 2'd0;
  localparam logic [1:0] RA_FUNC  = 2'd1;
  localparam logic [1:0] RA_STAT  = 2'd2;
  localparam logic [1:0] RA_STAGE = 2'd3;

  localparam int SB_READY = 0;
  localparam int SB_BUSY  = 1;
  localparam int SB_ACK   = 2;
  localparam int SB_ERR   = 3;

  // Stage reached by a command; RUN is left only through the barrier.
  function automatic sess_state_e stage_after(input sess_state_e cur,
                                              input sess_cmd_e   cmd,
                                              input logic        ready);
    sess_state_e nxt;
    nxt = cur;
    case (cur)
      ST_IDLE:    if (cmd == CMD_LOAD) nxt = ST_LOAD;
      ST_LOAD:    if (cmd == CMD_CONFIG) nxt = ST_CONFIG;
      ST_CONFIG:  if (cmd == CMD_START && ready) nxt = ST_RUN;
      ST_DONE:    if (cmd == CMD_COLLECT) nxt = ST_COLLECT;
      ST_COLLECT: begin
        if (cmd == CMD_LOAD) nxt = ST_LOAD;
        else if (cmd == CMD_END) nxt = ST_IDLE;
      end
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

  function automatic logic start_refused(input sess_state_e cur,
                                         input sess_cmd_e   cmd,
                                         input logic        ready);
    return (cmd == CMD_START) && !((cur == ST_CONFIG) && ready);
  endfunction

  function automatic logic [REG_W-1:0] status_word(input logic ready, input logic busy,
                                                   input logic ack, input logic err);
    logic [REG_W-1:0] w;
    w = '0;
    w[SB_READY] = ready;
    w[SB_BUSY]  = busy;
    w[SB_ACK]   = ack;
    w[SB_ERR]   = err;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] stage_word(input sess_state_e st);
    return {{(REG_W-3){1'b0}}, st};
  endfunction

endpackage

// File: rtl/sess_regs.sv
`timescale 1ns/1ps
module sess_regs
  import sess_pkg::*;
#(
  parameter int FUNC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              ack_set,
  input  logic              err_set,
  output logic              cmd_valid,
  output sess_cmd_e         cmd,
  output logic [FUNC_W-1:0] func_q,
  output logic              ack_q,
  output logic              err_q
);

  logic ack_clr;
  logic err_clr;
  logic func_wr;
  logic unused_wdata;

  assign cmd_valid    = wr && (addr == RA_CMD);
  assign cmd          = sess_cmd_e'(wdata[2:0]);
  assign func_wr      = wr && (addr == RA_FUNC);
  assign ack_clr      = wr && (addr == RA_STAT) && wdata[SB_ACK];
  assign err_clr      = wr && (addr == RA_STAT) && wdata[SB_ERR];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (func_wr) func_q <= wdata[FUNC_W-1:0];
      // a completion on the clearing edge is kept
      ack_q <= ack_set | (ack_q & ~ack_clr);
      err_q <= err_set | (err_q & ~err_clr);
    end
  end

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_q) && !$past(ack_clr)) |-> ack_q);

  // R6
  ack_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack_set) |-> ack_q);

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_q) && !$past(err_clr)) |-> err_q);

endmodule

// File: rtl/sess_seq.sv
`timescale 1ns/1ps
module sess_seq
  import sess_pkg::*;
#(
  parameter int FUNC_W  = 4,
  parameter int CFG_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  sess_cmd_e         cmd,
  input  logic [FUNC_W-1:0] func_q,
  input  logic              cu_done,
  output sess_state_e       state,
  output logic              cfg_busy,
  output logic              cfg_ready,
  output logic              cu_start,
  output logic [FUNC_W-1:0] cu_func,
  output logic              ack_set,
  output logic              err_set,
  output logic              unit_owns
);

  localparam int CNT_W = $clog2(CFG_LAT + 1);

  sess_cmd_e   cmd_eff;
  sess_state_e nxt;
  logic [CNT_W-1:0] cfg_cnt;
  logic cu_fin;
  logic host_fin;
  logic cfg_begin;

  assign cmd_eff   = cmd_valid ? cmd : CMD_NOP;
  assign nxt       = stage_after(state, cmd_eff, cfg_ready);
  assign cfg_begin = (state == ST_LOAD) && (nxt == ST_CONFIG);
  assign cfg_busy  = (cfg_cnt != '0);
  assign ack_set   = cu_done && (state == ST_RUN);
  assign err_set   = cmd_valid && start_refused(state, cmd, cfg_ready);
  assign unit_owns = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cfg_cnt   <= '0;
      cfg_ready <= 1'b0;
      cu_start  <= 1'b0;
      cu_func   <= '0;
      cu_fin    <= 1'b0;
      host_fin  <= 1'b0;
    end else begin
      cu_start <= 1'b0;
      if (state == ST_RUN) begin
        if (cu_fin && host_fin) begin
          state    <= ST_DONE;
          cu_fin   <= 1'b0;
          host_fin <= 1'b0;
        end else begin
          cu_fin   <= cu_fin | cu_done;
          host_fin <= host_fin | (cmd_eff == CMD_HDONE);
        end
      end else begin
        state <= nxt;
        if (nxt == ST_RUN) begin
          cu_start  <= 1'b1;
          cfg_ready <= 1'b0;
        end
        if (cfg_begin) begin
          cfg_cnt   <= CNT_W'(CFG_LAT);
          cfg_ready <= 1'b0;
          cu_func   <= func_q;
        end else if (cfg_busy) begin
          cfg_cnt <= cfg_cnt - 1'b1;
          if (cfg_cnt == CNT_W'(1)) cfg_ready <= 1'b1;
        end
      end
    end
  end

  // R3
  busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_busy && cfg_ready));

  // R4
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) != ST_RUN) |-> $past(cfg_ready));

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cu_start |-> (state == ST_RUN && $past(state) != ST_RUN));

  // R7
  barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_RUN && state != ST_RUN) |-> $past(cu_fin && host_fin));

endmodule

// File: rtl/sess_mem.sv
`timescale 1ns/1ps
module sess_mem #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unit_owns,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_ack,
  input  logic          cu_req,
  input  logic          cu_we,
  input  logic [AW-1:0] cu_addr,
  input  logic [DW-1:0] cu_wdata,
  output logic [DW-1:0] cu_rdata,
  output logic          cu_gnt
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  assign host_ack   = host_req && !unit_owns;
  assign cu_gnt     = cu_req && unit_owns;
  assign host_rdata = mem[host_addr];
  assign cu_rdata   = mem[cu_addr];

  always_ff @(posedge clk) begin
    if (host_ack && host_we)    mem[host_addr] <= host_wdata;
    else if (cu_gnt && cu_we)   mem[cu_addr]   <= cu_wdata;
  end

  // R8
  host_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && unit_owns) |-> !host_ack);

  // R8
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(host_req && unit_owns) && host_req && !unit_owns) |-> host_ack);

  // R9
  cu_gnt_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cu_gnt && host_ack));

endmodule

// File: rtl/accel_session_ctrl.sv
`timescale 1ns/1ps
module accel_session_ctrl
  import sess_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 4,
  parameter int FUNC_W  = 4,
  parameter int CFG_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              hmem_req,
  input  logic              hmem_we,
  input  logic [AW-1:0]     hmem_addr,
  input  logic [DW-1:0]     hmem_wdata,
  output logic [DW-1:0]     hmem_rdata,
  output logic              hmem_ack,
  output logic              host_irq,
  output logic              cu_start,
  output logic [FUNC_W-1:0] cu_func,
  input  logic              cu_done,
  input  logic              cu_mem_req,
  input  logic              cu_mem_we,
  input  logic [AW-1:0]     cu_mem_addr,
  input  logic [DW-1:0]     cu_mem_wdata,
  output logic [DW-1:0]     cu_mem_rdata,
  output logic              cu_mem_gnt
);

  logic              cmd_valid;
  sess_cmd_e         cmd;
  logic [FUNC_W-1:0] func_q;
  logic              ack_q;
  logic              err_q;
  logic              ack_set;
  logic              err_set;
  sess_state_e       state;
  logic              cfg_busy;
  logic              cfg_ready;
  logic              unit_owns;

  sess_regs #(.FUNC_W(FUNC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ack_set(ack_set), .err_set(err_set),
    .cmd_valid(cmd_valid), .cmd(cmd),
    .func_q(func_q), .ack_q(ack_q), .err_q(err_q)
  );

  sess_seq #(.FUNC_W(FUNC_W), .CFG_LAT(CFG_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd(cmd), .func_q(func_q), .cu_done(cu_done),
    .state(state), .cfg_busy(cfg_busy), .cfg_ready(cfg_ready),
    .cu_start(cu_start), .cu_func(cu_func),
    .ack_set(ack_set), .err_set(err_set), .unit_owns(unit_owns)
  );

  sess_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .unit_owns(unit_owns),
    .host_req(hmem_req), .host_we(hmem_we), .host_addr(hmem_addr),
    .host_wdata(hmem_wdata), .host_rdata(hmem_rdata), .host_ack(hmem_ack),
    .cu_req(cu_mem_req), .cu_we(cu_mem_we), .cu_addr(cu_mem_addr),
    .cu_wdata(cu_mem_wdata), .cu_rdata(cu_mem_rdata), .cu_gnt(cu_mem_gnt)
  );

  assign host_irq = ack_q;

  always_comb begin
    case (reg_addr)
      RA_FUNC:  reg_rdata = REG_W'(func_q);
      RA_STAT:  reg_rdata = status_word(cfg_ready, cfg_busy, ack_q, err_q);
      RA_STAGE: reg_rdata = stage_word(state);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: tb/accel_session_ctrl_test.sv
`timescale 1ns/1ps
module accel_session_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        hmem_req = 1'b0;
  logic        hmem_we = 1'b0;
  logic [3:0]  hmem_addr = 4'd0;
  logic [15:0] hmem_wdata = 16'd0;
  logic [15:0] hmem_rdata;
  logic        hmem_ack;
  logic        host_irq;
  logic        cu_start;
  logic [3:0]  cu_func;
  logic        cu_done = 1'b0;
  logic        cu_mem_req = 1'b0;
  logic        cu_mem_we = 1'b0;
  logic [3:0]  cu_mem_addr = 4'd0;
  logic [15:0] cu_mem_wdata = 16'd0;
  logic [15:0] cu_mem_rdata;
  logic        cu_mem_gnt;

  accel_session_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hmem_req(hmem_req), .hmem_we(hmem_we), .hmem_addr(hmem_addr),
    .hmem_wdata(hmem_wdata), .hmem_rdata(hmem_rdata), .hmem_ack(hmem_ack),
    .host_irq(host_irq), .cu_start(cu_start), .cu_func(cu_func), .cu_done(cu_done),
    .cu_mem_req(cu_mem_req), .cu_mem_we(cu_mem_we), .cu_mem_addr(cu_mem_addr),
    .cu_mem_wdata(cu_mem_wdata), .cu_mem_rdata(cu_mem_rdata), .cu_mem_gnt(cu_mem_gnt)
  );

  always #10 clk = ~clk;

  typedef struct {
    string       req;
    int          sig;
    logic [31:0] exp;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  function automatic logic [31:0] sample(input int s);
    case (s)
      0: return {24'd0, reg_rdata};
      1: return {31'd0, cu_start};
      2: return {31'd0, host_irq};
      3: return {31'd0, hmem_ack};
      4: return {31'd0, cu_mem_gnt};
      5: return {28'd0, cu_func};
      6: return {16'd0, hmem_rdata};
      default: return {16'd0, cu_mem_rdata};
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = sample(it.sig);
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s sig%0d actual=%0h expected=%0h", it.req, it.sig, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input string r, input int s, input logic [31:0] e);
    exp_t it;
    it.req = r; it.sig = s; it.exp = e;
    sb.push_back(it);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic chk_reg(input string r, input logic [1:0] a, input logic [7:0] e);
    reg_addr = a;
    push(r, 0, {24'd0, e});
    step();
  endtask

  task automatic host_access(input string r, input logic we, input logic [3:0] a,
                             input logic [15:0] d, input logic [15:0] exp_rd);
    hmem_req = 1'b1; hmem_we = we; hmem_addr = a; hmem_wdata = d;
    push(r, 3, 32'd1);
    if (!we) push(r, 6, {16'd0, exp_rd});
    step();
    hmem_req = 1'b0; hmem_we = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R1 reset state
    push("R1", 1, 0);
    push("R1", 2, 0);
    chk_reg("R1", 2'd3, 8'h00);
    chk_reg("R1", 2'd2, 8'h00);

    // R5 start in IDLE refused, sticky error
    wr_reg(2'd0, 8'd3);
    push("R5", 1, 0);
    chk_reg("R5", 2'd3, 8'h00);
    chk_reg("R5", 2'd2, 8'h08);
    chk_reg("R5", 2'd2, 8'h08);
    wr_reg(2'd2, 8'h08);
    chk_reg("R5", 2'd2, 8'h00);

    // R2 illegal and legal moves
    wr_reg(2'd0, 8'd5);
    chk_reg("R2", 2'd3, 8'h00);
    wr_reg(2'd0, 8'd1);
    chk_reg("R2", 2'd3, 8'h01);
    wr_reg(2'd0, 8'd4);
    chk_reg("R2", 2'd3, 8'h01);

    // R8 host loads operands outside RUN
    host_access("R8", 1'b1, 4'd3, 16'h00AA, 16'h0);
    host_access("R8", 1'b1, 4'd5, 16'h0001, 16'h0);
    host_access("R8", 1'b0, 4'd3, 16'h0, 16'h00AA);
    // R9 no grant outside RUN
    cu_mem_req = 1'b1; cu_mem_addr = 4'd3;
    push("R9", 4, 0);
    step();
    cu_mem_req = 1'b0;

    // R3 configuration latency
    wr_reg(2'd1, 8'd5);
    chk_reg("R3", 2'd1, 8'h05);
    wr_reg(2'd0, 8'd2);
    push("R3", 5, 5);
    chk_reg("R3", 2'd2, 8'h02);
    chk_reg("R3", 2'd2, 8'h02);
    chk_reg("R3", 2'd2, 8'h02);
    chk_reg("R3", 2'd2, 8'h02);
    chk_reg("R3", 2'd2, 8'h01);
    chk_reg("R3", 2'd3, 8'h02);

    // R4 start accepted
    wr_reg(2'd0, 8'd3);
    push("R4", 1, 1);
    chk_reg("R4", 2'd3, 8'h03);
    push("R4", 1, 0);
    chk_reg("R4", 2'd2, 8'h00);

    // R9 unit reads operand; R8 host write stalls
    cu_mem_req = 1'b1; cu_mem_we = 1'b0; cu_mem_addr = 4'd3;
    hmem_req = 1'b1; hmem_we = 1'b1; hmem_addr = 4'd5; hmem_wdata = 16'hBEEF;
    push("R9", 4, 1);
    push("R9", 7, 16'h00AA);
    push("R8", 3, 0);
    step();
    cu_mem_addr = 4'd5;
    push("R8", 7, 16'h0001);
    push("R8", 3, 0);
    step();
    cu_mem_we = 1'b1; cu_mem_addr = 4'd6; cu_mem_wdata = 16'h1234;
    push("R9", 4, 1);
    step();
    cu_mem_req = 1'b0; cu_mem_we = 1'b0;

    // R7 host done first, then unit done
    wr_reg(2'd0, 8'd4);
    push("R8", 3, 0);
    chk_reg("R7", 2'd3, 8'h03);
    cu_done = 1'b1;
    step();
    cu_done = 1'b0;
    push("R6", 2, 1);
    push("R8", 3, 0);
    chk_reg("R7", 2'd3, 8'h03);
    push("R8", 3, 1);
    chk_reg("R7", 2'd3, 8'h04);
    hmem_req = 1'b0; hmem_we = 1'b0;

    // R6 acknowledge held until cleared
    push("R6", 2, 1);
    chk_reg("R6", 2'd2, 8'h04);
    wr_reg(2'd2, 8'h04);
    push("R6", 2, 0);
    chk_reg("R6", 2'd2, 8'h00);

    // collect results
    wr_reg(2'd0, 8'd5);
    chk_reg("R2", 2'd3, 8'h05);
    host_access("R8", 1'b0, 4'd5, 16'h0, 16'hBEEF);
    host_access("R9", 1'b0, 4'd6, 16'h0, 16'h1234);

    // R10 second session with new function
    wr_reg(2'd0, 8'd1);
    chk_reg("R10", 2'd3, 8'h01);
    wr_reg(2'd1, 8'd9);
    wr_reg(2'd0, 8'd2);
    wr_reg(2'd0, 8'd3);
    push("R5", 1, 0);
    chk_reg("R5", 2'd3, 8'h02);
    chk_reg("R5", 2'd2, 8'h0A);
    step();
    push("R10", 5, 9);
    chk_reg("R3", 2'd2, 8'h09);
    wr_reg(2'd2, 8'h08);
    chk_reg("R5", 2'd2, 8'h01);
    wr_reg(2'd0, 8'd3);
    push("R4", 1, 1);
    chk_reg("R4", 2'd3, 8'h03);

    // R6 completion and clear in the same cycle; R7 unit done first
    cu_done = 1'b1;
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h04;
    step();
    cu_done = 1'b0; reg_wr = 1'b0;
    push("R6", 2, 1);
    chk_reg("R7", 2'd3, 8'h03);
    chk_reg("R7", 2'd3, 8'h03);
    wr_reg(2'd0, 8'd4);
    chk_reg("R7", 2'd3, 8'h03);
    chk_reg("R7", 2'd3, 8'h04);

    // R2 close the session
    wr_reg(2'd0, 8'd5);
    wr_reg(2'd0, 8'd6);
    chk_reg("R2", 2'd3, 8'h00);
    wr_reg(2'd2, 8'h04);
    push("R6", 2, 0);
    step();

    step();
    done_flag = 1'b1;
    report();
    $finish;
  end

endmodule